// File: doc/BRIEF.md
# Routed-Source GPIO Pad Controller

This block drives a bank of general-purpose pads. It has no register that holds output data. Each pad instead has two selector registers. The first picks the signal that becomes the pad's output level. The second picks the signal that becomes the pad's active-high output enable; when that enable is low the pad is released. Every selector can choose a constant low, a constant high, or one of the output or enable signals of the on-chip peripherals. Software gets ordinary GPIO behaviour by choosing the constant codes. It hands a pad to a peripheral by writing that peripheral's code instead. A top bit in each selector register inverts whatever was chosen.

Pad input levels go through a two-stage synchronizer. They are read back packed, one bit per pad, in two 32-bit words. All access goes over a plain 32-bit register port. A write is taken in the cycle its strobe is high. A read returns its data one cycle later with a valid flag. The port has no back-pressure: it accepts one request every cycle, and the caller must take the read data in the cycle it is flagged.

Top module: `padmux_ctrl`

## Requirements
- R1: After reset every pad output and every pad output enable is 0, and every selector register reads back 0.
- R2: In a pad's value selector (byte offset 0x50 + 8n for pad n), code 0 drives the pad output to 0 and code 1 drives it to 1, with the invert bit clear.
- R3: In a pad's enable selector (byte offset 0x54 + 8n), code 0 drives the pad output enable to 0 and code 1 drives it to 1, with the invert bit clear.
- R4: Select codes 2 to P+1, held in bits 7:0, route peripheral index code-2. A value selector takes that index of the peripheral output vector. An enable selector takes that index of the peripheral enable vector. P is the number of peripheral signals.
- R5: Any select code above P+1 yields 0 before inversion.
- R6: Bit 31 of a selector register inverts the chosen signal before it reaches the pad.
- R7: A selector register reads back its bit 31 and bits 7:0 as written, with every other bit 0.
- R8: Offset 0x48 returns the synchronized levels of pads 31..0 and offset 0x4C returns pads 63..32. A read issued in the cycle of a pad change, or one cycle later, still returns the old level. A read issued two cycles after the change returns the new level.
- R9: Writes to 0x48, 0x4C or any unmapped offset change no register and no pad. Reads of unmapped or misaligned offsets return 0.
- R10: Read data and the read-valid flag appear exactly one cycle after a read strobe, and the flag is low in every other cycle.
- R11: Writing the selector of one pad changes no other pad's output or output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd_en |
| bus_rdata | output | 32 | Read data |
| periph_out | input | NUM_PERIPH | Peripheral output-level signals |
| periph_oe | input | NUM_PERIPH | Peripheral output-enable signals |
| pad_in | input | NUM_PADS | Raw pad input levels |
| pad_out | output | NUM_PADS | Pad output levels |
| pad_oe | output | NUM_PADS | Pad output enables, active high |

## Verification
The assertions assume that reset is asserted from time zero until at least one clock edge has passed. They also assume the bus strobes and peripheral vectors are never unknown once reset is released. The stimulus changes every input on the falling clock edge and keeps all of them at defined values throughout. The pad input lines are driven at steady, fully defined levels, so the synchronizer never sees a change close to an edge. The offsets used are either the mapped word offsets or deliberately chosen unmapped and misaligned ones.

// File: rtl/padmux_pkg.sv
package padmux_pkg;
  localparam int SEL_W        = 8;
  localparam int INV_POS      = 31;
  localparam int WORD_W       = 32;
  localparam int CODE_LOW     = 0;
  localparam int CODE_HIGH    = 1;
  localparam int CODE_PERIPH0 = 2;
  localparam int IN_LO_OFF    = 'h48;
  localparam int IN_HI_OFF    = 'h4C;
  localparam int CFG_BASE     = 'h50;
endpackage

// File: rtl/padmux_insync.sv
module padmux_insync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;

  // R8
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage2 == $past(stage1));
endmodule

// File: rtl/padmux_regs.sv
module padmux_regs
  import padmux_pkg::*;
#(
  parameter int NUM_PADS = 64,
  parameter int ADDR_W   = 12
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic                             rd_en,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [WORD_W-1:0]                wdata,
  input  logic [NUM_PADS-1:0]              din_sync,
  output logic                             rvalid,
  output logic [WORD_W-1:0]                rdata,
  output logic [2*NUM_PADS-1:0][SEL_W-1:0] sel_q,
  output logic [2*NUM_PADS-1:0]            inv_q
);
  localparam int REGS  = 2 * NUM_PADS;
  localparam int IDX_W = $clog2(REGS);

  logic [ADDR_W-1:0] off;
  logic              cfg_hit;
  logic [IDX_W-1:0]  cfg_idx;
  logic [63:0]       din_wide;
  logic [WORD_W-1:0] rd_word;
  logic              unused_wbits;

  assign off      = addr - ADDR_W'(CFG_BASE);
  assign cfg_hit  = (addr >= ADDR_W'(CFG_BASE)) && (off[1:0] == 2'b00) &&
                    (off[ADDR_W-1:2] < (ADDR_W-2)'(REGS));
  assign cfg_idx  = off[IDX_W+1:2];
  assign din_wide = 64'(din_sync);
  assign unused_wbits = ^wdata[INV_POS-1:SEL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      inv_q <= '0;
    end else if (wr_en && cfg_hit) begin
      sel_q[cfg_idx] <= wdata[SEL_W-1:0];
      inv_q[cfg_idx] <= wdata[INV_POS];
    end
  end

  always_comb begin
    rd_word = '0;
    if (addr == ADDR_W'(IN_LO_OFF)) begin
      rd_word = din_wide[31:0];
    end else if (addr == ADDR_W'(IN_HI_OFF)) begin
      rd_word = din_wide[63:32];
    end else if (cfg_hit) begin
      rd_word[SEL_W-1:0] = sel_q[cfg_idx];
      rd_word[INV_POS]   = inv_q[cfg_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_word;
    end
  end

  // R10
  rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  // R10
  rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
  // R9
  din_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == ADDR_W'(IN_LO_OFF) || addr == ADDR_W'(IN_HI_OFF)))
      |=> ($stable(sel_q) && $stable(inv_q)));
endmodule

// File: rtl/padmux_route.sv
module padmux_route
  import padmux_pkg::*;
#(
  parameter int NUM_PADS   = 64,
  parameter int NUM_PERIPH = 16
) (
  input  logic [2*NUM_PADS-1:0][SEL_W-1:0] sel_q,
  input  logic [2*NUM_PADS-1:0]            inv_q,
  input  logic [NUM_PERIPH-1:0]            periph_out,
  input  logic [NUM_PERIPH-1:0]            periph_oe,
  output logic [NUM_PADS-1:0]              pad_out,
  output logic [NUM_PADS-1:0]              pad_oe
);
  function automatic logic pick(input logic [SEL_W-1:0] code,
                                input logic [NUM_PERIPH-1:0] src);
    logic r;
    r = (code == SEL_W'(CODE_HIGH));
    for (int k = 0; k < NUM_PERIPH; k++) begin
      if (code == SEL_W'(CODE_PERIPH0 + k)) r = src[k];
    end
    return r;
  endfunction

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
    assign pad_out[g] = pick(sel_q[2*g],   periph_out) ^ inv_q[2*g];
    assign pad_oe[g]  = pick(sel_q[2*g+1], periph_oe)  ^ inv_q[2*g+1];
  end
endmodule

// File: rtl/padmux_ctrl.sv
module padmux_ctrl
  import padmux_pkg::*;
#(
  parameter int NUM_PADS   = 64,
  parameter int NUM_PERIPH = 16,
  parameter int ADDR_W     = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr_en,
  input  logic                  bus_rd_en,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic                  bus_rvalid,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_PERIPH-1:0] periph_out,
  input  logic [NUM_PERIPH-1:0] periph_oe,
  input  logic [NUM_PADS-1:0]   pad_in,
  output logic [NUM_PADS-1:0]   pad_out,
  output logic [NUM_PADS-1:0]   pad_oe
);
  localparam int REGS = 2 * NUM_PADS;

  logic [NUM_PADS-1:0]         din_sync;
  logic [REGS-1:0][SEL_W-1:0]  sel_q;
  logic [REGS-1:0]             inv_q;

  padmux_insync #(.WIDTH(NUM_PADS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(din_sync)
  );

  padmux_regs #(.NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .rd_en(bus_rd_en),
    .addr(bus_addr), .wdata(bus_wdata), .din_sync(din_sync),
    .rvalid(bus_rvalid), .rdata(bus_rdata), .sel_q(sel_q), .inv_q(inv_q)
  );

  padmux_route #(.NUM_PADS(NUM_PADS), .NUM_PERIPH(NUM_PERIPH)) u_route (
    .sel_q(sel_q), .inv_q(inv_q), .periph_out(periph_out),
    .periph_oe(periph_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_chk
    // R2
    out_const_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[2*g] == SEL_W'(CODE_HIGH) && !inv_q[2*g]) |-> pad_out[g]);
    // R2
    out_const_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[2*g] == SEL_W'(CODE_LOW) && !inv_q[2*g]) |-> !pad_out[g]);
    // R3
    oe_const_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[2*g+1] == SEL_W'(CODE_LOW) && !inv_q[2*g+1]) |-> !pad_oe[g]);
    // R5
    out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[2*g] >= SEL_W'(CODE_PERIPH0 + NUM_PERIPH)) |-> (pad_out[g] == inv_q[2*g]));
  end
endmodule

// File: tb/test_padmux_ctrl.sv
module test_padmux_ctrl;
  localparam int N  = 64;
  localparam int P  = 4;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr_en = 1'b0;
  logic          bus_rd_en = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rvalid;
  logic [31:0]   bus_rdata;
  logic [P-1:0]  periph_out = '0;
  logic [P-1:0]  periph_oe = '0;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out;
  logic [N-1:0]  pad_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_sel [2*N];
  logic       m_inv [2*N];

  padmux_ctrl #(.NUM_PADS(N), .NUM_PERIPH(P), .ADDR_W(AW)) i_padmux_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .periph_out(periph_out), .periph_oe(periph_oe),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [7:0] s, input logic inv,
                                   input logic [P-1:0] v);
    logic r;
    if (s == 8'd1) r = 1'b1;
    else if (s >= 8'd2 && s < 8'(2 + P)) r = v[s - 8'd2];
    else r = 1'b0;
    return r ^ inv;
  endfunction

  task automatic check_pads(input string tag);
    logic [N-1:0] eo;
    logic [N-1:0] ee;
    for (int p = 0; p < N; p++) begin
      eo[p] = exp_bit(m_sel[2*p],   m_inv[2*p],   periph_out);
      ee[p] = exp_bit(m_sel[2*p+1], m_inv[2*p+1], periph_oe);
    end
    #1;
    check(pad_out === eo, {tag, " pad_out"}, 64'(pad_out), 64'(eo));
    check(pad_oe === ee,  {tag, " pad_oe"},  64'(pad_oe),  64'(ee));
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    check(bus_rvalid === 1'b1, "R10 rvalid after read", 64'(bus_rvalid), 64'd1);
    d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [63:0] pat;
    for (int i = 0; i < 2*N; i++) begin m_sel[i] = '0; m_inv[i] = 1'b0; end
    repeat (3) @(negedge clk);
    check(pad_out === '0 && pad_oe === '0, "R1 outputs in reset",
          64'(pad_out | pad_oe), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_rvalid === 1'b0, "R10 rvalid idle", 64'(bus_rvalid), 64'd0);
    check_pads("R1 after reset");
    bus_read(12'h050, rd);
    check(rd === 32'd0, "R1 pad0 value reg", 64'(rd), 64'd0);
    bus_read(12'h054 + 12'(8*(N-1)), rd);
    check(rd === 32'd0, "R1 last enable reg", 64'(rd), 64'd0);

    // Sweep every selector over all codes, both invert settings, two patterns
    for (int p = 0; p < N; p++) begin
      for (int w = 0; w < 2; w++) begin
        for (int c = 0; c < 8; c++) begin
          for (int iv = 0; iv < 2; iv++) begin
            int idx;
            logic [7:0] code;
            string tag;
            idx  = 2*p + w;
            code = (c == 7) ? 8'hFF : 8'(c);
            bus_write(12'h050 + 12'(4*idx), {iv[0], 23'd0, code});
            m_sel[idx] = code;
            m_inv[idx] = iv[0];
            if (c < 2) tag = (w == 0) ? "R2" : "R3";
            else if (c < 2 + P) tag = "R4";
            else tag = "R5";
            if (iv != 0) tag = {tag, "/R6"};
            tag = {tag, "/R11"};
            periph_out = 4'b0101; periph_oe = 4'b1100;
            check_pads(tag);
            periph_out = 4'b1010; periph_oe = 4'b0011;
            check_pads(tag);
          end
        end
      end
    end

    // Readback of every selector register
    for (int i = 0; i < 2*N; i++) begin
      logic [31:0] d;
      d = {i[0], 7'h55, 16'hAAAA, 8'(i*37 + 3)};
      bus_write(12'h050 + 12'(4*i), d);
      m_sel[i] = d[7:0];
      m_inv[i] = d[31];
    end
    for (int i = 0; i < 2*N; i++) begin
      logic [31:0] d;
      d = {i[0], 7'h55, 16'hAAAA, 8'(i*37 + 3)};
      bus_read(12'h050 + 12'(4*i), rd);
      check(rd === {d[31], 23'd0, d[7:0]}, "R7 readback", 64'(rd),
            64'({d[31], 23'd0, d[7:0]}));
    end
    check_pads("R11 after readback writes");

    // Writes to read-only and unmapped offsets
    bus_write(12'h048, 32'hFFFF_FFFF);
    bus_write(12'h04C, 32'hFFFF_FFFF);
    bus_write(12'h250, 32'h8000_0001);
    bus_write(12'h051, 32'h8000_0001);
    bus_write(12'h3FC, 32'h8000_0001);
    check_pads("R9 ignored writes");
    bus_read(12'h048, rd);
    check(rd === 32'd0, "R9 input word after write", 64'(rd), 64'd0);
    foreach (pat[k]) pat[k] = 1'b0;
    bus_read(12'h000, rd); check(rd === 32'd0, "R9 unmapped 0x000", 64'(rd), 64'd0);
    bus_read(12'h044, rd); check(rd === 32'd0, "R9 unmapped 0x044", 64'(rd), 64'd0);
    bus_read(12'h250, rd); check(rd === 32'd0, "R9 unmapped 0x250", 64'(rd), 64'd0);
    bus_read(12'h051, rd); check(rd === 32'd0, "R9 misaligned 0x051", 64'(rd), 64'd0);
    bus_read(12'h3FC, rd); check(rd === 32'd0, "R9 unmapped 0x3FC", 64'(rd), 64'd0);
    @(negedge clk);
    check(bus_rvalid === 1'b0, "R10 rvalid drops", 64'(bus_rvalid), 64'd0);

    // Input synchronizer latency and packing
    pat = 64'h0123_4567_89AB_CDEF;
    for (int r = 0; r < 3; r++) begin
      logic [63:0] old;
      old = pad_in;
      pad_in = pat;
      bus_read(12'h048, rd);
      check(rd === old[31:0], "R8 same-cycle read old", 64'(rd), 64'(old[31:0]));
      bus_read(12'h04C, rd);
      check(rd === old[63:32], "R8 next-cycle read old", 64'(rd), 64'(old[63:32]));
      bus_read(12'h048, rd);
      check(rd === pat[31:0], "R8 low word new", 64'(rd), 64'(pat[31:0]));
      bus_read(12'h04C, rd);
      check(rd === pat[63:32], "R8 high word new", 64'(rd), 64'(pat[63:32]));
      pat = (r == 0) ? ~pat : {pat[31:0], pat[63:32]} ^ 64'h8000_0001_0000_0001;
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule